// File: doc/BRIEF.md
# Two-Bit Hardware Cursor Compositor

This block lays a small cursor image over a stream of screen pixels on their way to the palette. Every cursor pixel is a two-bit code. The code either replaces the screen pixel with one of two fixed palette indices, or lets the screen pixel through, or inverts the screen pixel. The cursor is a square window of 64 by 64 pixels. Its top-left corner is set by two position registers. A one-row line buffer holds the codes for the cursor row now being drawn.

Timing logic outside the block supplies each pixel's coordinates with a valid strobe. The result comes out one clock later. The block also turns a programmed 10-bit cursor base and a requested row number into the byte address from which that row's definition is fetched. The base is scrambled with a constant before the address is formed. An outside agent fetches the 16 bytes of a row and writes them into the line buffer.

Top module: `cursor_compositor`

## Requirements
- R1: After reset, `out_valid` and `out_pix` are 0, the cursor is disabled, and the base register, X and Y registers hold 0.
- R2: Code 0 inside the window outputs palette index 8'h00.
- R3: Code 1 inside the window outputs palette index 8'hFF.
- R4: Code 2 inside the window outputs the screen pixel unchanged.
- R5: Code 3 inside the window outputs the bitwise inverse of the screen pixel.
- R6: When the cursor is disabled, or when the pixel lies outside the window (x < X, x >= X+64, y < Y or y >= Y+64), the screen pixel passes through unchanged.
- R7: For column offset d = x - X, the code is bits [2*(d%4)+1 : 2*(d%4)] of line-buffer byte d/4. The leftmost pixel of each byte sits in bits [1:0].
- R8: `fetch_addr` equals ((base XOR 10'h1DF) * 16'h800) + row * 16, held to 21 bits.
- R9: `out_valid` is `pix_valid` delayed by one clock, and `out_pix` is produced from the inputs of that earlier cycle.
- R10: A line-buffer write takes effect from the next clock. A pixel looked up in the same cycle as a write to its byte uses the old byte.
- R11: Register writes use `reg_addr`: 0 selects the base (`reg_wdata[9:0]`), 1 selects X (`[10:0]`), 2 selects Y (`[10:0]`) and 3 selects the enable (`[0]`). A write applies to pixels from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| lb_we | input | 1 | Line-buffer byte write strobe |
| lb_waddr | input | 4 | Line-buffer byte index |
| lb_wdata | input | 8 | Line-buffer byte data |
| fetch_row | input | 6 | Cursor row whose address is wanted |
| fetch_addr | output | 21 | Byte address of that row's definition |
| pix_valid | input | 1 | Pixel strobe |
| pix_x | input | 11 | Pixel column |
| pix_y | input | 11 | Pixel row |
| pix_in | input | 8 | Screen pixel index |
| out_valid | output | 1 | Output pixel strobe |
| out_pix | output | 8 | Composited pixel index |

## Verification
The line-buffer write and the per-pixel code lookup can happen in the same cycle, even on the same byte. The bench drives a lookup and a write to the byte under that lookup on one edge. It then requires that the output was built from the byte as it stood before the write, and that the next pixel sees the new byte. A register write that lands with a pixel is judged the same way: the move applies to the following pixel only.

// File: rtl/cursor_pkg.sv
// Package: shared widths, cursor code encoding and register selects.
// Assumes: all cursor modules compile after this package.
package cursor_pkg;
    localparam int PIX_W    = 8;
    localparam int COORD_W  = 11;
    localparam int BASE_W   = 10;
    localparam int REG_W    = 16;
    localparam int CUR_DIM  = 64;
    localparam int PIX_PER_BYTE = 4;
    localparam logic [BASE_W-1:0] BASE_SCRAMBLE = 10'h1DF;

    typedef enum logic [1:0] {
        CODE_BACK   = 2'd0,
        CODE_FORE   = 2'd1,
        CODE_CLEAR  = 2'd2,
        CODE_INVERT = 2'd3
    } cur_code_e;

    typedef enum logic [1:0] {
        SEL_BASE   = 2'd0,
        SEL_XPOS   = 2'd1,
        SEL_YPOS   = 2'd2,
        SEL_ENABLE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cursor_regs.sv
// Module: cursor control registers and the row fetch address generator.
// Assumes: reg_wdata is wide enough for the widest field; reset is synchronous.
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int BASE_BITS = BASE_W,
    parameter int CRD_BITS  = COORD_W,
    parameter int DIM       = CUR_DIM,
    parameter int UNIT_LOG2 = 11,
    localparam int ROW_BITS  = $clog2(DIM),
    localparam int ROW_BYTES = DIM / PIX_PER_BYTE,
    localparam int ADDR_BITS = BASE_BITS + UNIT_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic [ROW_BITS-1:0]  fetch_row,
    output logic [ADDR_BITS-1:0] fetch_addr,
    output logic [BASE_BITS-1:0] eff_base,
    output logic [CRD_BITS-1:0]  pos_x,
    output logic [CRD_BITS-1:0]  pos_y,
    output logic                 cur_en
);
    logic [BASE_BITS-1:0] base_q;

    // Register file update on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            pos_x  <= '0;
            pos_y  <= '0;
            cur_en <= 1'b0;
        end else if (reg_we) begin
            case (reg_sel_e'(reg_addr))
                SEL_BASE:   base_q <= reg_wdata[BASE_BITS-1:0];
                SEL_XPOS:   pos_x  <= reg_wdata[CRD_BITS-1:0];
                SEL_YPOS:   pos_y  <= reg_wdata[CRD_BITS-1:0];
                SEL_ENABLE: cur_en <= reg_wdata[0];
                default:    ;
            endcase
        end
    end

    // Unscramble base and form the row definition address.
    always_comb begin
        eff_base   = base_q ^ BASE_SCRAMBLE;
        fetch_addr = {eff_base, {UNIT_LOG2{1'b0}}}
                   + ADDR_BITS'(fetch_row) * ADDR_BITS'(ROW_BYTES);
    end
endmodule

// File: rtl/cursor_linebuf.sv
// Module: one-row store of packed cursor codes with a combinational code read.
// Assumes: a write is seen by reads from the next clock; leftmost pixel in low bits.
module cursor_linebuf
    import cursor_pkg::*;
#(
    parameter int DIM = CUR_DIM,
    localparam int BYTES     = DIM / PIX_PER_BYTE,
    localparam int BYTE_BITS = $clog2(BYTES),
    localparam int COL_BITS  = $clog2(DIM)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [BYTE_BITS-1:0] wr_idx,
    input  logic [7:0]           wr_data,
    input  logic [COL_BITS-1:0]  rd_col,
    output cur_code_e            rd_code
);
    logic [7:0] row_mem [BYTES];

    // Byte storage, one register per byte.
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                row_mem[b] <= '0;
            else if (wr_en && wr_idx == BYTE_BITS'(b))
                row_mem[b] <= wr_data;
        end
    end

    // Select the byte and the bit pair for the requested column.
    always_comb begin
        logic [7:0] sel_byte;
        sel_byte = row_mem[rd_col[COL_BITS-1:2]];
        rd_code  = cur_code_e'(sel_byte[{rd_col[1:0], 1'b0} +: 2]);
    end
endmodule

// File: rtl/cursor_mix.sv
// Module: window test and pixel selection with one output register.
// Assumes: position registers and code arrive from sibling modules combinationally.
module cursor_mix
    import cursor_pkg::*;
#(
    parameter int CRD_BITS = COORD_W,
    parameter int PW       = PIX_W,
    parameter int DIM      = CUR_DIM,
    localparam int COL_BITS = $clog2(DIM)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cur_en,
    input  logic [CRD_BITS-1:0] pos_x,
    input  logic [CRD_BITS-1:0] pos_y,
    input  logic                pix_valid,
    input  logic [CRD_BITS-1:0] pix_x,
    input  logic [CRD_BITS-1:0] pix_y,
    input  logic [PW-1:0]       pix_in,
    output logic [COL_BITS-1:0] col_off,
    input  cur_code_e           code,
    output logic                out_valid,
    output logic [PW-1:0]       out_pix
);
    logic [CRD_BITS:0] dx, dy;
    logic              in_win;
    logic [PW-1:0]     mixed;

    // Window hit test with one extra bit to catch negative offsets.
    always_comb begin
        dx      = {1'b0, pix_x} - {1'b0, pos_x};
        dy      = {1'b0, pix_y} - {1'b0, pos_y};
        in_win  = cur_en && !dx[CRD_BITS] && !dy[CRD_BITS]
                && (dx < (CRD_BITS+1)'(DIM)) && (dy < (CRD_BITS+1)'(DIM));
        col_off = dx[COL_BITS-1:0];
    end

    // Choose the pixel from the cursor code.
    always_comb begin
        mixed = pix_in;
        if (in_win) begin
            case (code)
                CODE_BACK:   mixed = '0;
                CODE_FORE:   mixed = '1;
                CODE_CLEAR:  mixed = pix_in;
                CODE_INVERT: mixed = ~pix_in;
                default:     mixed = pix_in;
            endcase
        end
    end

    // Output register giving one clock of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= pix_valid;
            out_pix   <= pix_valid ? mixed : '0;
        end
    end
endmodule

// File: rtl/cursor_compositor.sv
// Module: top of the two-bit cursor compositor.
// Assumes: an outside agent fills the line buffer for the row being drawn.
module cursor_compositor
    import cursor_pkg::*;
#(
    parameter int DIM = CUR_DIM,
    localparam int ROW_BITS  = $clog2(DIM),
    localparam int BYTE_BITS = $clog2(DIM / PIX_PER_BYTE),
    localparam int ADDR_BITS = BASE_W + 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic                 lb_we,
    input  logic [BYTE_BITS-1:0] lb_waddr,
    input  logic [7:0]           lb_wdata,
    input  logic [ROW_BITS-1:0]  fetch_row,
    output logic [ADDR_BITS-1:0] fetch_addr,
    input  logic                 pix_valid,
    input  logic [COORD_W-1:0]   pix_x,
    input  logic [COORD_W-1:0]   pix_y,
    input  logic [PIX_W-1:0]     pix_in,
    output logic                 out_valid,
    output logic [PIX_W-1:0]     out_pix
);
    logic [BASE_W-1:0]   eff_base;
    logic [COORD_W-1:0]  pos_x, pos_y;
    logic                cur_en;
    logic [ROW_BITS-1:0] col_off;
    cur_code_e           code;

    cursor_regs #(.DIM(DIM)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .fetch_row(fetch_row), .fetch_addr(fetch_addr),
        .eff_base(eff_base), .pos_x(pos_x), .pos_y(pos_y), .cur_en(cur_en)
    );

    cursor_linebuf #(.DIM(DIM)) u_lbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(lb_we), .wr_idx(lb_waddr),
        .wr_data(lb_wdata), .rd_col(col_off), .rd_code(code)
    );

    cursor_mix #(.DIM(DIM)) u_mix (
        .clk(clk), .rst_n(rst_n), .cur_en(cur_en), .pos_x(pos_x), .pos_y(pos_y),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in),
        .col_off(col_off), .code(code), .out_valid(out_valid), .out_pix(out_pix)
    );
endmodule

// File: rtl/cursor_compositor_chk.sv
// Module: property checker attached to the compositor top by bind.
// Assumes: samples on the rising clock; armed one clock after reset leaves.
module cursor_compositor_chk #(
    parameter int PW = 8,
    parameter int AW = 21,
    parameter int RW = 6,
    parameter int BW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_valid,
    input logic [PW-1:0] pix_in,
    input logic          out_valid,
    input logic [PW-1:0] out_pix,
    input logic          cur_en,
    input logic [RW-1:0] fetch_row,
    input logic [AW-1:0] fetch_addr,
    input logic [BW-1:0] eff_base
);
    logic armed;

    // Mark the first cycle whose past lies wholly after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_valid_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    p_valid_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    p_code_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && out_valid && out_pix != $past(pix_in) && out_pix != ~$past(pix_in))
        |-> (out_pix == '0 || out_pix == '1));

    p_disabled_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && out_valid && !$past(cur_en)) |-> out_pix == $past(pix_in));

    p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $stable(eff_base) && {1'b0, fetch_row} == {1'b0, $past(fetch_row)} + 1'b1)
        |-> fetch_addr == $past(fetch_addr) + AW'(16));
endmodule

bind cursor_compositor cursor_compositor_chk #(
    .PW(8), .AW(21), .RW(6), .BW(10)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_in(pix_in),
    .out_valid(out_valid), .out_pix(out_pix), .cur_en(cur_en),
    .fetch_row(fetch_row), .fetch_addr(fetch_addr), .eff_base(eff_base)
);

// File: tb/test_cursor_compositor.sv
module test_cursor_compositor;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        lb_we;
    logic [3:0]  lb_waddr;
    logic [7:0]  lb_wdata;
    logic [5:0]  fetch_row;
    logic [20:0] fetch_addr;
    logic        pix_valid;
    logic [10:0] pix_x, pix_y;
    logic [7:0]  pix_in;
    logic        out_valid;
    logic [7:0]  out_pix;

    int checks = 0;
    int fails  = 0;

    // Bench model state
    logic [7:0]  m_row [16];
    logic [10:0] m_x, m_y;
    logic        m_en;

    always #2 clk = ~clk;

    cursor_compositor i_cursor_compositor (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .lb_we(lb_we), .lb_waddr(lb_waddr),
        .lb_wdata(lb_wdata), .fetch_row(fetch_row), .fetch_addr(fetch_addr),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_pix(input logic [10:0] x, input logic [10:0] y,
                                           input logic [7:0] p);
        int dx, dy;
        logic [1:0] c;
        dx = int'(x) - int'(m_x);
        dy = int'(y) - int'(m_y);
        if (!m_en || dx < 0 || dy < 0 || dx >= 64 || dy >= 64) return p;
        c = m_row[dx / 4][2 * (dx % 4) +: 2];
        case (c)
            2'd0: return 8'h00;
            2'd1: return 8'hFF;
            2'd2: return p;
            default: return ~p;
        endcase
    endfunction

    function automatic logic [20:0] exp_addr(input logic [9:0] b, input logic [5:0] r);
        return (21'(b ^ 10'h1DF) << 11) + 21'(r) * 21'd16;
    endfunction

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            2'd1: m_x = d[10:0];
            2'd2: m_y = d[10:0];
            2'd3: m_en = d[0];
            default: ;
        endcase
    endtask

    task automatic wr_lb(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        lb_we = 1'b1; lb_waddr = a; lb_wdata = d;
        @(negedge clk);
        lb_we = 1'b0;
        m_row[a] = d;
    endtask

    // Drive one pixel and check the output one clock later.
    task automatic pixel(input string req, input logic [10:0] x, input logic [10:0] y,
                         input logic [7:0] p);
        logic [7:0] e;
        @(negedge clk);
        e = exp_pix(x, y, p);
        pix_valid = 1'b1; pix_x = x; pix_y = y; pix_in = p;
        @(negedge clk);
        pix_valid = 1'b0;
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check(req, 32'(out_pix), 32'(e));
    endtask

    initial begin
        #(4ns * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 1'b0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        lb_we = 0; lb_waddr = 0; lb_wdata = 0; fetch_row = 0;
        pix_valid = 0; pix_x = 0; pix_y = 0; pix_in = 0;
        m_x = 0; m_y = 0; m_en = 0;
        for (int i = 0; i < 16; i++) m_row[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 out_pix", 32'(out_pix), 0);
        check("R1 base", 32'(fetch_addr), 32'(exp_addr(10'h0, 6'd0)));
        rst_n = 1'b1;
        // R1: cursor disabled after reset, pixel at origin passes
        pixel("R1 disabled", 11'd0, 11'd0, 8'h5A);

        // R7: bytes laid out so codes 0,1,2,3 go left to right
        for (int i = 0; i < 16; i++) wr_lb(4'(i), 8'hE4);
        wr_reg(2'd1, 16'd100);
        wr_reg(2'd2, 16'd200);
        wr_reg(2'd3, 16'd1);
        pixel("R2 code0", 11'd100, 11'd200, 8'h3C);
        pixel("R3 code1", 11'd101, 11'd200, 8'h3C);
        pixel("R4 code2", 11'd102, 11'd200, 8'h3C);
        pixel("R5 code3", 11'd103, 11'd200, 8'h3C);
        pixel("R7 last col", 11'd163, 11'd263, 8'h11);
        pixel("R6 right edge", 11'd164, 11'd200, 8'h22);
        pixel("R6 left edge", 11'd99, 11'd200, 8'h33);
        pixel("R6 below", 11'd100, 11'd264, 8'h44);
        pixel("R6 above", 11'd100, 11'd199, 8'h55);
        wr_lb(4'd5, 8'h1B);
        pixel("R7 byte5 pix0", 11'd120, 11'd210, 8'hA5);
        pixel("R7 byte5 pix3", 11'd123, 11'd210, 8'hA5);

        // R10: same-cycle write and lookup on byte 0
        @(negedge clk);
        begin
            logic [7:0] e;
            e = exp_pix(11'd100, 11'd200, 8'h77);
            pix_valid = 1; pix_x = 11'd100; pix_y = 11'd200; pix_in = 8'h77;
            lb_we = 1; lb_waddr = 4'd0; lb_wdata = 8'hFF;
            @(negedge clk);
            pix_valid = 0; lb_we = 0;
            m_row[0] = 8'hFF;
            check("R10 old byte used", 32'(out_pix), 32'(e));
        end
        pixel("R10 new byte seen", 11'd100, 11'd200, 8'h77);

        // R11: position write coinciding with a pixel applies next clock
        @(negedge clk);
        begin
            logic [7:0] e;
            e = exp_pix(11'd100, 11'd200, 8'h66);
            pix_valid = 1; pix_x = 11'd100; pix_y = 11'd200; pix_in = 8'h66;
            reg_we = 1; reg_addr = 2'd1; reg_wdata = 16'd500;
            @(negedge clk);
            pix_valid = 0; reg_we = 0;
            m_x = 11'd500;
            check("R11 old pos used", 32'(out_pix), 32'(e));
        end
        pixel("R11 new pos", 11'd100, 11'd200, 8'h66);

        // R9: idle cycle shows no valid output
        @(negedge clk);
        check("R9 idle", 32'(out_valid), 0);

        // R8: fetch addresses, directed and random
        begin
            logic [9:0] b;
            logic [5:0] r;
            for (int i = 0; i < 20; i++) begin
                b = (i == 0) ? 10'h1DF : (i == 1) ? 10'h3FF : 10'($urandom);
                r = (i == 1) ? 6'd63 : 6'($urandom);
                wr_reg(2'd0, {6'd0, b});
                fetch_row = r;
                #1;
                check("R8 fetch", 32'(fetch_addr), 32'(exp_addr(b, r)));
            end
        end

        // Random mix, R2..R7
        for (int i = 0; i < 16; i++) wr_lb(4'(i), 8'($urandom));
        wr_reg(2'd1, 16'd300);
        wr_reg(2'd2, 16'd40);
        for (int i = 0; i < 300; i++) begin
            if (i == 150) wr_reg(2'd3, 16'd0);
            if (i == 200) wr_reg(2'd3, 16'd1);
            pixel("R2-R7 random", 11'(280 + $urandom_range(0, 100)),
                  11'(20 + $urandom_range(0, 100)), 8'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule